// File: doc/BRIEF.md
# In-Fabric Logic Analyzer Capture Unit

The block is a logic analyzer placed inside the design. On every edge of the design's own clock it looks at a group of trigger ports. Several match units compare each port against a programmed value. Each match unit has a per-bit care mask and can test for equality or inequality. A trigger sequencer with several levels watches the match results. It must see the condition of each level, one level after another, before it declares the trigger. While the block is armed, a Boolean qualifier chosen from the match units decides on each cycle whether the probe bus is written into an on-chip circular sample memory.

A programmed trigger position keeps up to that many qualified samples from before the trigger. After the trigger, the block fills the remaining slots of the memory with qualified samples, then raises done and stops writing. The host pulses arm to start a capture and pulses clear to abandon one. It watches three status flags. It reads the capture back through an index port, where index 0 is always the oldest sample kept.

Top module: `la_capture`

## Requirements
- R1: After reset, armed_o, triggered_o and done_o are all 0.
- R2: A match unit in equal mode (its cfg_neq_i bit 0) hits when every bit set in its care mask equals the programmed value. Bits that are clear in the mask have no effect. Unit u compares trigger port u / UNITS_PER_PORT.
- R3: A match unit in not-equal mode (its cfg_neq_i bit 1) hits exactly when the masked compare of R2 fails.
- R4: Level k is met when every unit selected in its select field hits. An empty field is always met. Only the current level is evaluated, and the sequencer rises by at most one level per cycle. When cfg_last_lvl_i is met, triggered_o rises on the next cycle and stays high until the next arm or clear.
- R5: When the qualifier select field is empty, every armed cycle is stored. Otherwise a cycle is stored only when at least one selected unit hits.
- R6: The trigger position cfg_pre_i is latched at arm. The block keeps the newest min(qualified pre-trigger samples, position) samples from before the trigger, and trig_idx_o reports that count.
- R7: Qualified samples from the trigger cycle onward count as post-trigger samples. When DEPTH minus the position of them have been stored, done_o rises, armed_o falls and no further sample is written.
- R8: rd_data_o shows, one cycle after rd_idx_i is set, the kept sample with that index in capture order. Index 0 is the oldest.
- R9: Arming again sets the sequencer back to level 0, empties the buffer and clears triggered_o and done_o.
- R10: A clear pulse drops armed_o, triggered_o and done_o, and it takes priority over arm. A trigger condition after a clear has no effect.
- R11: armed_o is 1 on the cycle after an arm pulse. The arm cycle itself is not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Design clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start a capture (pulse) |
| clear_i | input | 1 | Abandon capture and clear status (pulse) |
| probe_i | input | PROBE_W | Sampled data bus |
| trig_i | input | NUM_PORTS*PORT_W | Trigger ports, port p at bits p*PORT_W |
| cfg_val_i | input | NUM_UNITS*PORT_W | Compare value per unit |
| cfg_care_i | input | NUM_UNITS*PORT_W | Care mask per unit, 1 = compared |
| cfg_neq_i | input | NUM_UNITS | Compare mode per unit, 1 = not-equal |
| cfg_lvl_sel_i | input | NUM_LEVELS*NUM_UNITS | Unit select field per sequencer level |
| cfg_last_lvl_i | input | LVL_W | Final sequencer level |
| cfg_qual_sel_i | input | NUM_UNITS | Units used by the storage qualifier |
| cfg_pre_i | input | AW | Trigger position (pre-trigger samples) |
| rd_idx_i | input | AW | Readback index, 0 = oldest |
| armed_o | output | 1 | Capture running |
| triggered_o | output | 1 | Final level reached |
| done_o | output | 1 | Buffer complete |
| trig_idx_o | output | AW | Index of first post-trigger sample |
| rd_data_o | output | PROBE_W | Readback sample |

## Verification
The assertions check the following on every cycle: the status flags follow arm and clear; done never coexists with armed and never appears without a trigger; triggered_o holds; the sequencer level never skips; trig_idx_o stays within the trigger position; no memory write occurs while disarmed. Only the bench's scenarios can show the rest. These are the masked and inverted compares, the refusal to trigger on events that arrive out of order, the work of the qualifier, the trimming of pre-trigger history when the trigger comes early or late, and the chronological order of the readback.

// File: rtl/la_pkg.sv
package la_pkg;
  typedef enum logic {CMP_EQ = 1'b0, CMP_NE = 1'b1} cmp_mode_e;

  typedef struct packed {
    logic armed;
    logic trig;
    logic done;
  } cap_state_t;
endpackage

// File: rtl/la_match.sv
module la_match
  import la_pkg::*;
#(
  parameter int NUM_PORTS      = 2,
  parameter int PORT_W         = 8,
  parameter int UNITS_PER_PORT = 2,
  localparam int NUM_UNITS     = NUM_PORTS * UNITS_PER_PORT
) (
  input  logic [NUM_PORTS*PORT_W-1:0] trig_i,
  input  logic [NUM_UNITS*PORT_W-1:0] val_i,
  input  logic [NUM_UNITS*PORT_W-1:0] care_i,
  input  logic [NUM_UNITS-1:0]        neq_i,
  output logic [NUM_UNITS-1:0]        hit_o
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int P = u / UNITS_PER_PORT;
    logic [PORT_W-1:0] diff;
    logic              same;
    cmp_mode_e         mode;
    assign diff  = (trig_i[P*PORT_W +: PORT_W] ^ val_i[u*PORT_W +: PORT_W])
                   & care_i[u*PORT_W +: PORT_W];
    assign same  = (diff == '0);
    assign mode  = cmp_mode_e'(neq_i[u]);
    assign hit_o[u] = (mode == CMP_NE) ? ~same : same;
  end
endmodule

// File: rtl/la_seq.sv
module la_seq #(
  parameter int NUM_UNITS  = 4,
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          restart_i,
  input  logic                          run_i,
  input  logic [NUM_UNITS-1:0]          hit_i,
  input  logic [NUM_LEVELS*NUM_UNITS-1:0] lvl_sel_i,
  input  logic [LVL_W-1:0]              last_i,
  output logic                          fire_o,
  output logic [LVL_W-1:0]              lvl_o
);
  logic [NUM_LEVELS-1:0] lvl_ok;
  logic [LVL_W-1:0]      lvl_q;
  logic                  cur_ok, at_last;

  // NUM_LEVELS is a power of two, so every level index is in range
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    assign lvl_ok[l] = &(hit_i | ~lvl_sel_i[l*NUM_UNITS +: NUM_UNITS]);
  end

  assign cur_ok  = lvl_ok[lvl_q];
  assign at_last = (lvl_q == last_i);
  assign fire_o  = run_i & cur_ok & at_last;
  assign lvl_o   = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        lvl_q <= '0;
    else if (restart_i)                 lvl_q <= '0;
    else if (run_i && cur_ok && !at_last) lvl_q <= lvl_q + 1'b1;
  end
endmodule

// File: rtl/la_buffer.sv
module la_buffer #(
  parameter int PROBE_W = 16,
  parameter int DEPTH   = 256,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [PROBE_W-1:0] wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [PROBE_W-1:0] rdata_o
);
  logic [PROBE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/la_capture.sv
module la_capture
  import la_pkg::*;
#(
  parameter int NUM_PORTS      = 2,
  parameter int PORT_W         = 8,
  parameter int UNITS_PER_PORT = 2,
  parameter int NUM_LEVELS     = 4,
  parameter int PROBE_W        = 16,
  parameter int DEPTH          = 256,
  localparam int NUM_UNITS     = NUM_PORTS * UNITS_PER_PORT,
  localparam int AW            = $clog2(DEPTH),
  localparam int LVL_W         = $clog2(NUM_LEVELS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            arm_i,
  input  logic                            clear_i,
  input  logic [PROBE_W-1:0]              probe_i,
  input  logic [NUM_PORTS*PORT_W-1:0]     trig_i,
  input  logic [NUM_UNITS*PORT_W-1:0]     cfg_val_i,
  input  logic [NUM_UNITS*PORT_W-1:0]     cfg_care_i,
  input  logic [NUM_UNITS-1:0]            cfg_neq_i,
  input  logic [NUM_LEVELS*NUM_UNITS-1:0] cfg_lvl_sel_i,
  input  logic [LVL_W-1:0]                cfg_last_lvl_i,
  input  logic [NUM_UNITS-1:0]            cfg_qual_sel_i,
  input  logic [AW-1:0]                   cfg_pre_i,
  input  logic [AW-1:0]                   rd_idx_i,
  output logic                            armed_o,
  output logic                            triggered_o,
  output logic                            done_o,
  output logic [AW-1:0]                   trig_idx_o,
  output logic [PROBE_W-1:0]              rd_data_o
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  cap_state_t           st_q;
  logic [NUM_UNITS-1:0] hit;
  logic [LVL_W-1:0]     seq_lvl;
  logic                 fire, qual, mem_we, post_phase, arm_go, run;
  logic [AW-1:0]        wptr_q, trig_ptr_q, pre_cnt_q, pre_pos_q, rd_addr;
  logic [AW:0]          post_cnt_q, post_next, post_len;

  la_match #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .UNITS_PER_PORT(UNITS_PER_PORT)
  ) u_match (
    .trig_i(trig_i), .val_i(cfg_val_i), .care_i(cfg_care_i),
    .neq_i(cfg_neq_i), .hit_o(hit)
  );

  assign arm_go = arm_i & ~clear_i;
  assign run    = st_q.armed & ~st_q.trig;

  la_seq #(.NUM_UNITS(NUM_UNITS), .NUM_LEVELS(NUM_LEVELS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(arm_go), .run_i(run),
    .hit_i(hit), .lvl_sel_i(cfg_lvl_sel_i), .last_i(cfg_last_lvl_i),
    .fire_o(fire), .lvl_o(seq_lvl)
  );

  // empty qualifier field keeps every armed cycle
  assign qual       = (cfg_qual_sel_i == '0) | (|(hit & cfg_qual_sel_i));
  assign mem_we     = st_q.armed & ~arm_i & ~clear_i & qual;
  assign post_phase = st_q.trig | fire;
  assign post_len   = DEPTH_L - {1'b0, pre_pos_q};
  assign post_next  = post_cnt_q + {{AW{1'b0}}, mem_we};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= '0;
      wptr_q     <= '0;
      trig_ptr_q <= '0;
      pre_cnt_q  <= '0;
      pre_pos_q  <= '0;
      post_cnt_q <= '0;
    end else if (clear_i) begin
      st_q <= '0;
    end else if (arm_i) begin
      st_q       <= '{armed: 1'b1, trig: 1'b0, done: 1'b0};
      wptr_q     <= '0;
      pre_cnt_q  <= '0;
      post_cnt_q <= '0;
      pre_pos_q  <= cfg_pre_i;
    end else if (st_q.armed) begin
      if (mem_we) wptr_q <= wptr_q + 1'b1;
      if (fire) begin
        st_q.trig  <= 1'b1;
        trig_ptr_q <= wptr_q;
      end
      if (mem_we && !post_phase && pre_cnt_q < pre_pos_q)
        pre_cnt_q <= pre_cnt_q + 1'b1;
      if (post_phase) begin
        post_cnt_q <= post_next;
        if (post_next == post_len) begin
          st_q.done  <= 1'b1;
          st_q.armed <= 1'b0;
        end
      end
    end
  end

  assign rd_addr = trig_ptr_q - pre_cnt_q + rd_idx_i;

  la_buffer #(.PROBE_W(PROBE_W), .DEPTH(DEPTH)) u_buf (
    .clk_i(clk_i), .we_i(mem_we), .waddr_i(wptr_q), .wdata_i(probe_i),
    .raddr_i(rd_addr), .rdata_o(rd_data_o)
  );

  assign armed_o     = st_q.armed;
  assign triggered_o = st_q.trig;
  assign done_o      = st_q.done;
  assign trig_idx_o  = pre_cnt_q;
endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk #(
  parameter int AW    = 8,
  parameter int LVL_W = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          arm_i,
  input logic          clear_i,
  input logic          armed_o,
  input logic          triggered_o,
  input logic          done_o,
  input logic [AW-1:0] trig_idx_o,
  input logic [AW-1:0] pre_pos_q,
  input logic          mem_we,
  input logic [LVL_W-1:0] seq_lvl
);
  AST_DONE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !armed_o); // R7
  AST_DONE_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> triggered_o); // R7
  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_o |-> !mem_we); // R7
  AST_ARM_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !clear_i) |=> (armed_o && !triggered_o && !done_o)); // R9
  AST_CLEAR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!armed_o && !triggered_o && !done_o)); // R10
  AST_TRIG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o && !arm_i && !clear_i) |=> triggered_o); // R4
  AST_LVL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (seq_lvl == $past(seq_lvl)) || (seq_lvl == $past(seq_lvl) + 1'b1)); // R4
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_idx_o <= pre_pos_q); // R6
endmodule

bind la_capture la_capture_chk #(.AW(AW), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .clear_i(clear_i),
  .armed_o(armed_o), .triggered_o(triggered_o), .done_o(done_o),
  .trig_idx_o(trig_idx_o), .pre_pos_q(pre_pos_q), .mem_we(mem_we),
  .seq_lvl(seq_lvl)
);

// File: tb/la_capture_tb.sv
module la_capture_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        arm_i = 0, clear_i = 0;
  logic [15:0] probe_i = '0;
  logic [7:0]  t0 = '0, t1 = '0;
  logic [7:0]  cv [4];
  logic [7:0]  cc [4];
  logic [3:0]  cn = '0;
  logic [3:0]  ls [4];
  logic [1:0]  last = '0;
  logic [3:0]  qs = '0;
  logic [7:0]  pre = '0;
  logic [7:0]  rd_idx = '0;
  logic [15:0] trig_bus;
  logic [31:0] val_bus, care_bus;
  logic [15:0] sel_bus;
  logic        armed_o, triggered_o, done_o;
  logic [7:0]  trig_idx_o;
  logic [15:0] rd_data_o;

  always_comb begin
    trig_bus = {t1, t0};
    for (int u = 0; u < 4; u++) begin
      val_bus[u*8 +: 8]  = cv[u];
      care_bus[u*8 +: 8] = cc[u];
      sel_bus[u*4 +: 4]  = ls[u];
    end
  end

  la_capture u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .clear_i(clear_i),
    .probe_i(probe_i), .trig_i(trig_bus), .cfg_val_i(val_bus),
    .cfg_care_i(care_bus), .cfg_neq_i(cn), .cfg_lvl_sel_i(sel_bus),
    .cfg_last_lvl_i(last), .cfg_qual_sel_i(qs), .cfg_pre_i(pre),
    .rd_idx_i(rd_idx), .armed_o(armed_o), .triggered_o(triggered_o),
    .done_o(done_o), .trig_idx_o(trig_idx_o), .rd_data_o(rd_data_o)
  );

  int total = 0, fails = 0;
  bit finished = 0;
  logic [15:0] cyc = '0;
  bit m_armed = 0, m_trig = 0, m_done = 0;
  int m_lvl = 0, m_pre = 0;
  logic [15:0] pre_q[$], post_q[$], exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit hit(input int u);
    logic [7:0] p;
    bit eq;
    p  = (u < 2) ? t0 : t1;
    eq = (((p ^ cv[u]) & cc[u]) == 8'h00);
    return cn[u] ? !eq : eq;
  endfunction

  // reference model: one armed cycle
  task automatic model(input bit arm, input bit clr);
    logic [3:0] h;
    bit ok, fire, q;
    if (clr) begin
      m_armed = 0; m_trig = 0; m_done = 0;
    end else if (arm) begin
      m_armed = 1; m_trig = 0; m_done = 0; m_lvl = 0; m_pre = int'(pre);
      pre_q.delete(); post_q.delete();
    end else if (m_armed) begin
      for (int u = 0; u < 4; u++) h[u] = hit(u);
      ok   = ((h | ~ls[m_lvl]) == 4'hF);
      fire = !m_trig && ok && (m_lvl == int'(last));
      if (!m_trig && ok && m_lvl != int'(last)) m_lvl++;
      q = (qs == 4'h0) || ((h & qs) != 4'h0);
      if (q) begin
        if (m_trig || fire) post_q.push_back(probe_i);
        else begin
          pre_q.push_back(probe_i);
          if (pre_q.size() > m_pre) void'(pre_q.pop_front());
        end
      end
      if (fire) m_trig = 1;
      if (m_trig && post_q.size() == DEPTH - m_pre) begin
        m_done = 1; m_armed = 0;
      end
    end
  endtask

  // driver: inputs applied after a falling edge, outputs checked at the next one
  task automatic step(input logic [7:0] a, input logic [7:0] b, input bit arm, input bit clr);
    t0 = a; t1 = b; arm_i = arm; clear_i = clr; probe_i = cyc;
    model(arm, clr);
    @(negedge clk);
    arm_i = 0; clear_i = 0; cyc++;
    chk(triggered_o == m_trig, "R4 triggered_o", triggered_o, m_trig);
    chk(done_o == m_done, "R7 done_o", done_o, m_done);
    chk(armed_o == m_armed, "R7 armed_o", armed_o, m_armed);
  endtask

  task automatic run_out(input bit odd_walk);
    int n = 0;
    while (!m_done && n < 1000) begin
      step(odd_walk ? 8'(n) : 8'h00, 8'h00, 0, 0);
      n++;
    end
    chk(done_o, "R7 capture completes", done_o, 1);
  endtask

  // scoreboard: expected samples queued, monitor loop pops and compares
  task automatic readback();
    foreach (pre_q[i])  exp_q.push_back(pre_q[i]);
    foreach (post_q[i]) exp_q.push_back(post_q[i]);
    chk(trig_idx_o == 8'(pre_q.size()), "R6 trig_idx_o", trig_idx_o, pre_q.size());
    for (int i = 0; exp_q.size() > 0; i++) begin
      logic [15:0] e;
      rd_idx = 8'(i);
      @(negedge clk);
      e = exp_q.pop_front();
      chk(rd_data_o == e, "R8 readback order", rd_data_o, e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    cv[0] = 8'h5A; cc[0] = 8'hFF;
    cv[1] = 8'h00; cc[1] = 8'h01;
    cv[2] = 8'h03; cc[2] = 8'h0F;
    cv[3] = 8'hC3; cc[3] = 8'hFF;
    for (int l = 0; l < 4; l++) ls[l] = 4'h0;
    repeat (3) @(negedge clk);
    chk(!armed_o && !triggered_o && !done_o, "R1 reset status",
        {armed_o, triggered_o, done_o}, 0);
    rst_ni = 1;
    @(negedge clk);

    // A: two levels, masked equal compare, out-of-order event ignored
    ls[0] = 4'b0001; ls[1] = 4'b0100; last = 2'd1; qs = 4'h0; pre = 8'd10;
    step(8'h00, 8'h00, 1, 0);
    chk(armed_o == 1'b1, "R11 armed after arm", armed_o, 1);
    for (int i = 0; i < 15; i++) step(8'(i), 8'h10, 0, 0);
    step(8'h00, 8'hF3, 0, 0);
    chk(!triggered_o, "R4 level-1 event before level 0", triggered_o, 0);
    step(8'h5A, 8'h00, 0, 0);
    step(8'h00, 8'h00, 0, 0);
    step(8'h00, 8'hA3, 0, 0);
    chk(triggered_o, "R2 masked match triggers", triggered_o, 1);
    run_out(0);
    readback();

    // B: re-arm, not-equal unit as qualifier, early trigger with few pre samples
    ls[0] = 4'b1000; last = 2'd0; qs = 4'b0010; cn = 4'b0010; pre = 8'd200;
    step(8'h00, 8'h00, 1, 0);
    chk(!triggered_o && !done_o, "R9 re-arm clears flags", {triggered_o, done_o}, 0);
    for (int i = 0; i < 10; i++) step(8'(i), 8'h00, 0, 0);
    step(8'h0B, 8'hC3, 0, 0);
    chk(triggered_o, "R3 trigger after not-equal setup", triggered_o, 1);
    run_out(1);
    chk(trig_idx_o == 8'd5, "R5 only odd pre samples kept", trig_idx_o, 5);
    readback();

    // C: clear abandons capture
    ls[0] = 4'b0001; last = 2'd0; qs = 4'h0; cn = 4'h0; pre = 8'd5;
    step(8'h00, 8'h00, 1, 0);
    for (int i = 0; i < 3; i++) step(8'h01, 8'h00, 0, 0);
    step(8'h5A, 8'h00, 0, 1);
    chk(!armed_o, "R10 clear disarms", armed_o, 0);
    step(8'h5A, 8'h00, 0, 0);
    chk(!triggered_o, "R10 no trigger after clear", triggered_o, 0);

    // D: empty level passes, zero trigger position
    ls[0] = 4'b0000; ls[1] = 4'b0001; last = 2'd1; pre = 8'd0;
    step(8'h00, 8'h00, 1, 0);
    step(8'h5A, 8'h00, 0, 0);
    chk(!triggered_o, "R4 one level per cycle", triggered_o, 0);
    step(8'h5A, 8'h00, 0, 0);
    chk(triggered_o, "R4 empty level then final", triggered_o, 1);
    run_out(0);
    readback();

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule